// File: doc/BRIEF.md
# Multi-channel DShot frame transmitter

This block drives a group of motor command lines in lockstep. On a start strobe it captures one 16-bit command word per channel, together with a channel enable mask, a symbol-rate code, a polarity bit and a bidirectional-mode bit. It then shifts every word out at the same time. Each symbol is cut into three phases of equal length. A shared phase timer paces all lanes, so every enabled line changes level on the same clock edge.

After the last symbol the lines stay at their idle level for three more phases, which is one full symbol time, and `done_o` pulses. In bidirectional mode the enabled lanes then drop their output enable for a reply window, so an external receiver can listen on the pad, and afterwards they drive the idle level again. Building the command word and decoding any reply are handled elsewhere.

Top module: `dshot_frame_tx`

## Requirements
- R1: A start strobe seen while idle captures `frame_i`, `chan_en_i`, `rate_sel_i`, `invert_i` and `bidir_i`. The 16 symbols of channel c (bits `frame_i[c*16 +: 16]`) go out most significant bit first, starting with the clock edge that accepted the strobe.
- R2: Each symbol is three equal phases: active level, then the bit value, then inactive level. A 1 is active for two phases and a 0 for one phase.
- R3: The phase length in clocks is CLK_HZ / (3 × rate). Rate code 0 selects 150k, code 1 selects 300k, and codes 2 and 3 select 600k symbols per second. `busy_o` is high from the accepting edge until the frame, including any reply window, has ended.
- R4: After the 16th symbol every line holds idle for three phases. In the clock that follows, `done_o` is high for exactly one cycle.
- R5: With `invert_i` = 0 the active level is 1 and the idle/inactive level is 0. With `invert_i` = 1 every level is inverted.
- R6: All enabled lines change level together, and only on a phase boundary.
- R7: A disabled channel stays at the idle level for the whole frame and keeps its output enable high.
- R8: In bidirectional mode, the enabled channels drop `line_oe_o` right after the idle hold, for CLK_HZ × 30 / 10^6 + (48 × phase × 11) / 10 clocks, and then drive idle again. Outside that window every output enable is high.
- R9: A start strobe that arrives while busy is ignored. Changes on the configuration inputs during a frame do not affect it.
- R10: The asynchronous active-low reset returns the block to idle at once: lines 0, all output enables 1, `busy_o` and `done_o` 0. This also applies in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| frame_i | input | NUM_CH*16 | One command word per channel |
| chan_en_i | input | NUM_CH | Per-channel enable |
| rate_sel_i | input | 2 | Symbol-rate code |
| invert_i | input | 1 | Polarity select |
| bidir_i | input | 1 | Bidirectional (reply window) mode |
| line_o | output | NUM_CH | Per-channel line level |
| line_oe_o | output | NUM_CH | Per-channel pad output enable |
| busy_o | output | 1 | Frame, hold or reply window in progress |
| done_o | output | 1 | One-cycle pulse at the end of the idle hold |

## Verification
The bench builds the block with NUM_CH = 4 and a notional CLK_HZ of 9 MHz. With those values the phase is exactly 20, 10 and 5 clocks and the reply windows are 1326, 798 and 534 clocks. Every rate, both polarities and the bidirectional turnaround can therefore be measured to the exact clock in a short run. Four channels are enough to mix enabled and disabled lanes in one frame and to show that they stay in step.

// File: rtl/dshot_tx_pkg.sv
`timescale 1ns/1ps
package dshot_tx_pkg;

  localparam int unsigned SYMS       = 16;
  localparam int unsigned PH_PER_SYM = 3;
  localparam int unsigned HOLD_PH    = 3;
  localparam int unsigned SYM_W      = $clog2(SYMS);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_REPLY = 2'd3
  } tx_state_e;

  // Symbols per second for a rate code.
  function automatic int unsigned rate_hz(input logic [1:0] code);
    case (code)
      2'd0:    return 150_000;
      2'd1:    return 300_000;
      default: return 600_000;
    endcase
  endfunction

  // Clocks per phase: a third of one symbol time, never below one.
  function automatic int unsigned phase_div(input int unsigned clk_hz,
                                            input logic [1:0] code);
    int unsigned d;
    d = clk_hz / (PH_PER_SYM * rate_hz(code));
    return (d == 0) ? 1 : d;
  endfunction

  // Reply window: fixed microseconds plus 1.1 frame times, in clocks.
  function automatic int unsigned reply_len(input int unsigned clk_hz,
                                            input int unsigned div,
                                            input int unsigned base_us);
    longint unsigned base_clk, frame_clk;
    base_clk  = (longint'(clk_hz) * base_us) / 1_000_000;
    frame_clk = (longint'(SYMS * PH_PER_SYM) * div * 11) / 10;
    return int'(base_clk + frame_clk);
  endfunction

endpackage

// File: rtl/dshot_phase_timer.sv
`timescale 1ns/1ps
module dshot_phase_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dshot_frame_seq.sv
`timescale 1ns/1ps
module dshot_frame_seq
  import dshot_tx_pkg::*;
#(
  parameter int unsigned WIN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             bidir_i,
  input  logic [WIN_W-1:0] win_i,
  output tx_state_e        state_o,
  output logic [1:0]       ph_o,
  output logic [SYM_W-1:0] sym_o,
  output logic             start_accept_o,
  output logic             hold_end_o,
  output logic             done_o
);
  tx_state_e        state_q;
  logic [1:0]       ph_q;
  logic [SYM_W-1:0] sym_q;
  logic [WIN_W-1:0] rc_q;
  logic             done_q;
  logic             last_ph;

  assign last_ph        = (ph_q == 2'(PH_PER_SYM - 1));
  assign start_accept_o = (state_q == ST_IDLE) && start_i;
  assign hold_end_o     = (state_q == ST_HOLD) && tick_i && last_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      sym_q   <= '0;
      rc_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= hold_end_o;
      case (state_q)
        ST_IDLE: begin
          if (start_accept_o) begin
            state_q <= ST_SEND;
            ph_q    <= '0;
            sym_q   <= '0;
          end
        end
        ST_SEND: begin
          if (tick_i) begin
            if (last_ph) begin
              ph_q <= '0;
              if (sym_q == SYM_W'(SYMS - 1)) state_q <= ST_HOLD;
              else                          sym_q   <= sym_q + 1'b1;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (tick_i) begin
            if (last_ph) begin
              ph_q    <= '0;
              rc_q    <= '0;
              state_q <= bidir_i ? ST_REPLY : ST_IDLE;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
        end
        default: begin
          if (rc_q == win_i - 1'b1) state_q <= ST_IDLE;
          else                      rc_q    <= rc_q + 1'b1;
        end
      endcase
    end
  end

  assign state_o = state_q;
  assign ph_o    = ph_q;
  assign sym_o   = sym_q;
  assign done_o  = done_q;
endmodule

// File: rtl/dshot_lane.sv
`timescale 1ns/1ps
module dshot_lane
  import dshot_tx_pkg::*;
(
  input  logic [SYMS-1:0]  word_i,
  input  logic             en_i,
  input  logic             inv_i,
  input  logic             in_send_i,
  input  logic             in_reply_i,
  input  logic [1:0]       ph_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic             line_o,
  output logic             oe_o
);
  logic cur_bit;
  logic active;

  // Most significant bit goes first.
  assign cur_bit = word_i[SYM_W'(SYMS - 1) - sym_i];
  assign active  = in_send_i && ((ph_i == 2'd0) || ((ph_i == 2'd1) && cur_bit));
  assign line_o  = (en_i && active) ^ inv_i;
  assign oe_o    = !(en_i && in_reply_i);
endmodule

// File: rtl/dshot_frame_tx.sv
`timescale 1ns/1ps
module dshot_frame_tx
  import dshot_tx_pkg::*;
#(
  parameter int unsigned NUM_CH        = 4,
  parameter int unsigned CLK_HZ        = 100_000_000,
  parameter int unsigned REPLY_BASE_US = 30
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [NUM_CH*SYMS-1:0] frame_i,
  input  logic [NUM_CH-1:0]      chan_en_i,
  input  logic [1:0]             rate_sel_i,
  input  logic                   invert_i,
  input  logic                   bidir_i,
  output logic [NUM_CH-1:0]      line_o,
  output logic [NUM_CH-1:0]      line_oe_o,
  output logic                   busy_o,
  output logic                   done_o
);
  localparam int unsigned DIV_R0 = phase_div(CLK_HZ, 2'd0);
  localparam int unsigned DIV_R1 = phase_div(CLK_HZ, 2'd1);
  localparam int unsigned DIV_R2 = phase_div(CLK_HZ, 2'd2);
  localparam int unsigned WIN_R0 = reply_len(CLK_HZ, DIV_R0, REPLY_BASE_US);
  localparam int unsigned WIN_R1 = reply_len(CLK_HZ, DIV_R1, REPLY_BASE_US);
  localparam int unsigned WIN_R2 = reply_len(CLK_HZ, DIV_R2, REPLY_BASE_US);
  localparam int unsigned DIV_W  = $clog2(DIV_R0 + 1);
  localparam int unsigned WIN_W  = $clog2(WIN_R0 + 1);

  // Divisor and window chosen from the raw rate code; latched at start.
  logic [DIV_W-1:0] div_sel;
  logic [WIN_W-1:0] win_sel;
  always_comb begin
    case (rate_sel_i)
      2'd0:    begin div_sel = DIV_W'(DIV_R0); win_sel = WIN_W'(WIN_R0); end
      2'd1:    begin div_sel = DIV_W'(DIV_R1); win_sel = WIN_W'(WIN_R1); end
      default: begin div_sel = DIV_W'(DIV_R2); win_sel = WIN_W'(WIN_R2); end
    endcase
  end

  // Named internal events, also observed by the bound checker.
  tx_state_e        state;
  logic [1:0]       ph;
  logic [SYM_W-1:0] sym;
  logic             start_accept;
  logic             hold_end;
  logic             phase_tick;
  logic             in_send;
  logic             in_reply;
  logic             timer_run;

  // Configuration captured on an accepted start.
  logic [NUM_CH*SYMS-1:0] word_q;
  logic [NUM_CH-1:0]      en_q;
  logic [DIV_W-1:0]       div_q;
  logic [WIN_W-1:0]       win_q;
  logic                   inv_q;
  logic                   bidir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      en_q    <= '0;
      div_q   <= DIV_W'(DIV_R0);
      win_q   <= WIN_W'(WIN_R0);
      inv_q   <= 1'b0;
      bidir_q <= 1'b0;
    end else if (start_accept) begin
      word_q  <= frame_i;
      en_q    <= chan_en_i;
      div_q   <= div_sel;
      win_q   <= win_sel;
      inv_q   <= invert_i;
      bidir_q <= bidir_i;
    end
  end

  assign in_send   = (state == ST_SEND);
  assign in_reply  = (state == ST_REPLY);
  assign timer_run = in_send || (state == ST_HOLD);
  assign busy_o    = (state != ST_IDLE);

  dshot_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (timer_run),
    .div_i  (div_q),
    .tick_o (phase_tick)
  );

  dshot_frame_seq #(.WIN_W(WIN_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .tick_i         (phase_tick),
    .bidir_i        (bidir_q),
    .win_i          (win_q),
    .state_o        (state),
    .ph_o           (ph),
    .sym_o          (sym),
    .start_accept_o (start_accept),
    .hold_end_o     (hold_end),
    .done_o         (done_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    dshot_lane u_lane (
      .word_i     (word_q[c*SYMS +: SYMS]),
      .en_i       (en_q[c]),
      .inv_i      (inv_q),
      .in_send_i  (in_send),
      .in_reply_i (in_reply),
      .ph_i       (ph),
      .sym_i      (sym),
      .line_o     (line_o[c]),
      .oe_o       (line_oe_o[c])
    );
  end
endmodule

// File: rtl/dshot_frame_tx_chk.sv
`timescale 1ns/1ps
module dshot_frame_tx_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned WORD_W = 64,
  parameter int unsigned DIV_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic [NUM_CH-1:0] line_o,
  input logic [NUM_CH-1:0] line_oe_o,
  input logic              in_send,
  input logic              in_reply,
  input logic              phase_tick,
  input logic              hold_end,
  input logic              start_accept,
  input logic [NUM_CH-1:0] en_q,
  input logic              inv_q,
  input logic [WORD_W-1:0] word_q,
  input logic [DIV_W-1:0]  div_q
);
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> busy_o);

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(word_q) && $stable(div_q) && $stable(en_q)));

  p_done_after_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_end |=> done_o);

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_idle_outside_send_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_send |-> (line_o == {NUM_CH{inv_q}}));

  p_edges_on_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_send && $past(in_send) && !$past(phase_tick)) |-> $stable(line_o));

  p_oe_outside_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_reply |-> (&line_oe_o));

  p_release_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_reply |-> (line_oe_o == ~en_q));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dis
    p_disabled_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[c] |-> ((line_o[c] == inv_q) && line_oe_o[c]));
  end
endmodule

bind dshot_frame_tx dshot_frame_tx_chk #(
  .NUM_CH (NUM_CH),
  .WORD_W (NUM_CH*dshot_tx_pkg::SYMS),
  .DIV_W  (DIV_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .line_o       (line_o),
  .line_oe_o    (line_oe_o),
  .in_send      (in_send),
  .in_reply     (in_reply),
  .phase_tick   (phase_tick),
  .hold_end     (hold_end),
  .start_accept (start_accept),
  .en_q         (en_q),
  .inv_q        (inv_q),
  .word_q       (word_q),
  .div_q        (div_q)
);

// File: tb/tb_dshot_frame_tx.sv
`timescale 1ns/1ps
module tb_dshot_frame_tx;
  localparam int NCH  = 4;
  localparam int BCLK = 9_000_000;

  typedef struct packed {
    logic [1:0]  rate;
    logic        inv;
    logic        bidir;
    logic [3:0]  en;
    logic [63:0] words;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 4'hF, 64'h8001_A5C3_0000_FFFF},
    '{2'd1, 1'b1, 1'b0, 4'hF, 64'h7FFE_0F0F_FEDC_1234},
    '{2'd2, 1'b0, 1'b1, 4'h5, 64'h5555_C0DE_AAAA_3C96},
    '{2'd2, 1'b1, 1'b1, 4'hF, 64'hFFFF_0001_8000_E71B},
    '{2'd0, 1'b1, 1'b1, 4'hA, 64'h1357_9BDF_2468_ACE0},
    '{2'd3, 1'b0, 1'b0, 4'h3, 64'h0000_0000_F00D_BEEF},
    '{2'd1, 1'b0, 1'b1, 4'h0, 64'hDEAD_BEEF_CAFE_F00D}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [NCH*16-1:0] frame_i = '0;
  logic [NCH-1:0] chan_en_i = '0;
  logic [1:0] rate_sel_i = '0;
  logic invert_i = 1'b0;
  logic bidir_i = 1'b0;
  logic [NCH-1:0] line_o, line_oe_o;
  logic busy_o, done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dshot_frame_tx #(.NUM_CH(NCH), .CLK_HZ(BCLK), .REPLY_BASE_US(30)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_i(frame_i),
    .chan_en_i(chan_en_i), .rate_sel_i(rate_sel_i), .invert_i(invert_i),
    .bidir_i(bidir_i), .line_o(line_o), .line_oe_o(line_oe_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Phase length from R3: 9 MHz / (3 * rate).
  function automatic int exp_div(input logic [1:0] r);
    case (r)
      2'd0:    return 20;
      2'd1:    return 10;
      default: return 5;
    endcase
  endfunction

  // Reply window from R8: 30 us at 9 MHz is 270 clocks, plus 1.1 frames.
  function automatic int exp_win(input int d);
    return 270 + (16 * 3 * d * 11) / 10;
  endfunction

  task automatic run_vec(input vec_t v, input bit disturb);
    int d, w, fe, he, endi;
    int wcnt [NCH];
    int lvl_err, oe_err, wid_err, busy_n, rel_n, done_at, done_n;
    lvl_err = 0; oe_err = 0; wid_err = 0; busy_n = 0; rel_n = 0;
    done_at = -1; done_n = 0;
    d = exp_div(v.rate); w = exp_win(d);
    fe = 48 * d; he = 51 * d;
    endi = he + (v.bidir ? w : 0);
    for (int c = 0; c < NCH; c++) wcnt[c] = 0;
    @(negedge clk);
    frame_i = v.words; chan_en_i = v.en; rate_sel_i = v.rate;
    invert_i = v.inv; bidir_i = v.bidir; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i <= endi; i++) begin
      for (int c = 0; c < NCH; c++) begin
        int sym, ph;
        bit b, act, e_lvl, e_oe;
        sym = i / (3 * d);
        ph  = (i / d) % 3;
        b   = (i < fe) ? v.words[c*16 + 15 - sym] : 1'b0;
        act = (i < fe) && v.en[c] && ((ph == 0) || (ph == 1 && b));
        e_lvl = act ^ v.inv;
        e_oe  = !(v.bidir && v.en[c] && i >= he && i < endi);
        if (line_o[c] !== e_lvl) lvl_err++;
        if (line_oe_o[c] !== e_oe) oe_err++;
        if (i < fe) begin
          if (line_o[c] == !v.inv) wcnt[c]++;
          if ((i % (3 * d)) == 3 * d - 1) begin
            if (wcnt[c] != (v.en[c] ? (b ? 2 * d : d) : 0)) wid_err++;
            wcnt[c] = 0;
          end
        end
      end
      if (busy_o) busy_n++;
      if (line_oe_o != '1) rel_n++;
      if (done_o) begin
        done_n++;
        if (done_at < 0) done_at = i;
      end
      if (disturb && i == 7) begin
        start_i = 1'b1; frame_i = ~v.words; chan_en_i = ~v.en;
        rate_sel_i = v.rate + 2'd1; invert_i = ~v.inv; bidir_i = ~v.bidir;
      end
      if (disturb && i == 8) start_i = 1'b0;
      @(negedge clk);
    end
    chk(disturb ? "R9 levels with inputs disturbed" : "R1 R5 R7 levels", lvl_err, 0);
    chk("R2 active pulse widths", wid_err, 0);
    chk("R3 busy length", busy_n, endi);
    chk("R4 done position", done_at, he);
    chk("R4 done pulse count", done_n, 1);
    chk("R8 release window", rel_n, (v.bidir && v.en != 0) ? w : 0);
    chk("R8 output enables", oe_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: state while in reset and just after release.
    chk("R10 line in reset", line_o, 0);
    chk("R10 oe in reset", line_oe_o, 4'hF);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 busy after reset", busy_o, 0);
    chk("R10 done after reset", done_o, 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k], k[0]);

    // R1 back-to-back: a new frame right after one ends.
    run_vec(VECS[5], 1'b0);
    run_vec(VECS[0], 1'b0);

    // R10 reset in the middle of a bidirectional inverted frame.
    @(negedge clk);
    frame_i = '1; chan_en_i = 4'hF; rate_sel_i = 2'd2; invert_i = 1'b1;
    bidir_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (40) @(negedge clk);
    chk("R10 busy before mid-frame reset", busy_o, 1);
    rst_n = 1'b0;
    #1;
    chk("R10 busy after mid-frame reset", busy_o, 0);
    chk("R10 line after mid-frame reset", line_o, 0);
    chk("R10 oe after mid-frame reset", line_oe_o, 4'hF);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 stays idle after reset", busy_o, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule